// File: doc/BRIEF.md
# Granule-Tagged Memory with Reservation

This block is a small on-chip memory split into fixed 32-byte granules. Each granule carries one validity tag bit. Capability-sized accesses move a whole aligned granule together with its tag. Ordinary data stores of 1, 2, 4 or 8 bytes update only the bytes they cover and always clear the tag of the granule they land in. This means a tag can only be set by a capability store of a full granule.

A single request port carries an opcode, byte address, size code, write data and tag bit. Every request gets exactly one response on the following clock. The response carries read data, the tag, an ok flag and an error flag. A load-reserve sets a link bit. A store-conditional of either width commits only while that link bit is set, and a failed store-conditional leaves data and tag untouched. A misaligned access or an unknown opcode returns an error and changes nothing.

The response sequencer is a two-state machine:
- ST_IDLE means no response is due. It moves to ST_RESP when a request is presented, and stays in ST_IDLE otherwise.
- ST_RESP means a response is on the port this cycle. It stays in ST_RESP if another request arrives, and returns to ST_IDLE if none does.

Top module: `tmem_top`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high on the next cycle. `rsp_valid` is low in any cycle not preceded by a request.
- R2: Reset clears every granule tag and the link bit, and holds `rsp_valid` low.
- R3: Opcode 2 (capability store) at a granule-aligned address writes all 256 bits of `req_wdata` and sets the granule tag to `req_tag`. Opcode 0 (capability load) returns the granule's 256 bits and its tag, with `rsp_ok`=1.
- R4: Opcode 4 (data store) writes 1, 2, 4 or 8 bytes for size codes 0, 1, 2, 3. The store is little-endian: byte k of `req_wdata` lands at granule byte `addr[4:0]`+k, and all other bytes of the granule keep their value.
- R5: A committed data store, plain (opcode 4) or conditional (opcode 5), clears the tag of granule `addr[8:5]`.
- R6: Opcode 1 (load-reserve) returns data and tag exactly as opcode 0 does, and sets the link bit.
- R7: A store-conditional (opcode 3 capability, opcode 5 data) issued while the link bit is clear responds with `rsp_ok`=0 and changes neither data nor tag.
- R8: A store-conditional issued while the link bit is set commits like its plain counterpart, responds with `rsp_ok`=1, and clears the link bit.
- R9: A committed plain store into the reserved granule clears the link bit. A store into any other granule leaves the link bit set.
- R10: The following cases respond with `rsp_err`=1 and `rsp_ok`=0, and leave data, tags and the link bit unchanged:
  - a capability opcode (0 to 3) with `addr[4:0]` nonzero;
  - a data opcode whose address is not a multiple of its byte count;
  - opcode 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode: 0 cap load, 1 load-reserve, 2 cap store, 3 cap store-cond, 4 data store, 5 data store-cond |
| req_addr | input | 9 | Byte address; bits 8:5 select the granule |
| req_size | input | 2 | Data store size code (bytes = 1 << code) |
| req_wdata | input | 256 | Store data; data stores use the low 64 bits |
| req_tag | input | 1 | Tag written by capability stores |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 256 | Granule data for loads, zero otherwise |
| rsp_tag | output | 1 | Granule tag for loads, zero otherwise |
| rsp_ok | output | 1 | Request committed (loads, plain stores, successful conditionals) |
| rsp_err | output | 1 | Misaligned access or unknown opcode |

## Verification
Capability stores of distinct full-width patterns with both tag values, each read back, separate a working tag store from one that ignores or sticks the tag. Data stores of every size at the upper and lower edges of a granule, each read back, reveal byte-lane placement errors and confirm that the tag was cleared. Store-conditionals are tried in four situations: with no reservation, right after a load-reserve, after a plain store to the reserved granule, and after a store elsewhere. Together these distinguish a link bit that is never set, never cleared, or cleared by the wrong granule. Misaligned and unknown requests are followed by reads and by a conditional that must still succeed, which shows they altered nothing.

// File: rtl/tmem_pkg.sv
package tmem_pkg;

    localparam int TAG_FIELD_W = 8;
    localparam int DATA_LANE_W = 64;

    typedef enum logic [2:0] {
        OP_CAP_RD      = 3'd0,
        OP_CAP_RD_RSV  = 3'd1,
        OP_CAP_WR      = 3'd2,
        OP_CAP_WR_COND = 3'd3,
        OP_DAT_WR      = 3'd4,
        OP_DAT_WR_COND = 3'd5
    } tmem_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic err;
        logic is_read;
        logic is_rsv;
        logic is_write;
        logic is_cond;
        logic is_cap;
    } req_class_t;

endpackage

// File: rtl/tmem_decode.sv
module tmem_decode
    import tmem_pkg::*;
#(
    parameter int GRAN_BYTES = 32,
    parameter int GIDX_W     = 4,
    localparam int OFF_W     = $clog2(GRAN_BYTES),
    localparam int ADDR_W    = OFF_W + GIDX_W
) (
    input  logic [2:0]            op_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [1:0]            size_i,
    output req_class_t            cls_o,
    output logic [GIDX_W-1:0]     gidx_o,
    output logic [OFF_W-1:0]      off_o,
    output logic [GRAN_BYTES-1:0] ben_o
);

    logic [OFF_W-1:0]      span_m1;
    logic [GRAN_BYTES-1:0] run;
    logic                  cap_mis;
    logic                  dat_mis;

    assign off_o  = addr_i[OFF_W-1:0];
    assign gidx_o = addr_i[ADDR_W-1:OFF_W];

    always_comb begin
        // Byte count minus one gives the low-bit mask a naturally aligned access must clear.
        span_m1 = OFF_W'((1 << size_i) - 1);
        run     = GRAN_BYTES'((1 << (1 << size_i)) - 1);
        cap_mis = (off_o != '0);
        dat_mis = ((off_o & span_m1) != '0);
    end

    always_comb begin
        cls_o = '0;
        ben_o = '0;
        unique case (op_i)
            OP_CAP_RD: begin
                cls_o.is_read = 1'b1;
                cls_o.is_cap  = 1'b1;
                cls_o.err     = cap_mis;
            end
            OP_CAP_RD_RSV: begin
                cls_o.is_read = 1'b1;
                cls_o.is_rsv  = 1'b1;
                cls_o.is_cap  = 1'b1;
                cls_o.err     = cap_mis;
            end
            OP_CAP_WR: begin
                cls_o.is_write = 1'b1;
                cls_o.is_cap   = 1'b1;
                cls_o.err      = cap_mis;
                ben_o          = '1;
            end
            OP_CAP_WR_COND: begin
                cls_o.is_write = 1'b1;
                cls_o.is_cond  = 1'b1;
                cls_o.is_cap   = 1'b1;
                cls_o.err      = cap_mis;
                ben_o          = '1;
            end
            OP_DAT_WR: begin
                cls_o.is_write = 1'b1;
                cls_o.err      = dat_mis;
                ben_o          = run << off_o;
            end
            OP_DAT_WR_COND: begin
                cls_o.is_write = 1'b1;
                cls_o.is_cond  = 1'b1;
                cls_o.err      = dat_mis;
                ben_o          = run << off_o;
            end
            default: begin
                cls_o.err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tmem_store.sv
module tmem_store
    import tmem_pkg::*;
#(
    parameter int NUM_GRANULES = 16,
    parameter int GRAN_BYTES   = 32,
    localparam int GIDX_W      = $clog2(NUM_GRANULES),
    localparam int GRAN_BITS   = GRAN_BYTES * 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [GIDX_W-1:0]       gidx_i,
    input  logic [GRAN_BYTES-1:0]   ben_i,
    input  logic [GRAN_BITS-1:0]    wdata_i,
    input  logic [TAG_FIELD_W-1:0]  tag_i,
    output logic [GRAN_BITS-1:0]    rdata_o,
    output logic [TAG_FIELD_W-1:0]  rtag_o,
    output logic [NUM_GRANULES-1:0] tag_bits_o
);

    logic [GRAN_BITS-1:0]   data_arr [NUM_GRANULES];
    logic [TAG_FIELD_W-1:0] tag_arr  [NUM_GRANULES];

    for (genvar g = 0; g < NUM_GRANULES; g++) begin : g_gran
        logic [GRAN_BITS-1:0]   data_q;
        logic [TAG_FIELD_W-1:0] tag_q;
        logic                   hit;

        assign hit = (gidx_i == GIDX_W'(g));

        always_ff @(posedge clk) begin
            if (we_i && hit) begin
                for (int b = 0; b < GRAN_BYTES; b++) begin
                    if (ben_i[b]) begin
                        data_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
                    end
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q <= '0;
            end else if (we_i && hit) begin
                tag_q <= tag_i;
            end
        end

        assign data_arr[g]   = data_q;
        assign tag_arr[g]    = tag_q;
        assign tag_bits_o[g] = tag_q[0];
    end

    assign rdata_o = data_arr[gidx_i];
    assign rtag_o  = tag_arr[gidx_i];

endmodule

// File: rtl/tmem_link.sv
module tmem_link #(
    parameter int GIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [GIDX_W-1:0] set_gidx_i,
    input  logic              drop_i,
    input  logic              wr_i,
    input  logic [GIDX_W-1:0] wr_gidx_i,
    output logic              link_o,
    output logic [GIDX_W-1:0] link_gidx_o
);

    logic              link_q;
    logic [GIDX_W-1:0] gidx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            gidx_q <= '0;
        end else if (set_i) begin
            link_q <= 1'b1;
            gidx_q <= set_gidx_i;
        end else if (drop_i || (wr_i && link_q && (wr_gidx_i == gidx_q))) begin
            link_q <= 1'b0;
        end
    end

    assign link_o      = link_q;
    assign link_gidx_o = gidx_q;

endmodule

// File: rtl/tmem_top.sv
module tmem_top
    import tmem_pkg::*;
#(
    parameter int NUM_GRANULES = 16,
    parameter int GRAN_BYTES   = 32,
    localparam int GIDX_W      = $clog2(NUM_GRANULES),
    localparam int OFF_W       = $clog2(GRAN_BYTES),
    localparam int ADDR_W      = GIDX_W + OFF_W,
    localparam int GRAN_BITS   = GRAN_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [GRAN_BITS-1:0] req_wdata,
    input  logic                 req_tag,
    output logic                 rsp_valid,
    output logic [GRAN_BITS-1:0] rsp_rdata,
    output logic                 rsp_tag,
    output logic                 rsp_ok,
    output logic                 rsp_err
);

    req_class_t               cls;
    logic [GIDX_W-1:0]        gidx;
    logic [OFF_W-1:0]         off;
    logic [GRAN_BYTES-1:0]    ben;
    logic [GRAN_BITS-1:0]     wdata_al;
    logic [TAG_FIELD_W-1:0]   tag_val;
    logic [GRAN_BITS-1:0]     rd_data;
    logic [TAG_FIELD_W-1:0]   rd_tag;
    logic [NUM_GRANULES-1:0]  tag_bits;
    logic                     link_q;
    logic [GIDX_W-1:0]        link_gidx;
    logic                     accept;
    logic                     commit;
    logic                     do_write;
    rsp_state_e               st_q;
    rsp_state_e               st_d;

    tmem_decode #(
        .GRAN_BYTES (GRAN_BYTES),
        .GIDX_W     (GIDX_W)
    ) u_decode (
        .op_i   (req_op),
        .addr_i (req_addr),
        .size_i (req_size),
        .cls_o  (cls),
        .gidx_o (gidx),
        .off_o  (off),
        .ben_o  (ben)
    );

    // A conditional commits only while the link is held; everything else commits when legal.
    assign accept   = req_valid && !cls.err;
    assign commit   = accept && (!cls.is_cond || link_q);
    assign do_write = commit && cls.is_write;

    always_comb begin
        if (cls.is_cap) begin
            wdata_al = req_wdata;
            tag_val  = {{(TAG_FIELD_W-1){1'b0}}, req_tag};
        end else begin
            wdata_al = GRAN_BITS'(req_wdata[DATA_LANE_W-1:0]) << {off, 3'b000};
            tag_val  = '0;
        end
    end

    tmem_store #(
        .NUM_GRANULES (NUM_GRANULES),
        .GRAN_BYTES   (GRAN_BYTES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (do_write),
        .gidx_i     (gidx),
        .ben_i      (ben),
        .wdata_i    (wdata_al),
        .tag_i      (tag_val),
        .rdata_o    (rd_data),
        .rtag_o     (rd_tag),
        .tag_bits_o (tag_bits)
    );

    tmem_link #(
        .GIDX_W (GIDX_W)
    ) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (commit && cls.is_rsv),
        .set_gidx_i  (gidx),
        .drop_i      (commit && cls.is_cond),
        .wr_i        (do_write),
        .wr_gidx_i   (gidx),
        .link_o      (link_q),
        .link_gidx_o (link_gidx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = req_valid ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_tag   <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
        end else if (req_valid) begin
            rsp_rdata <= (accept && cls.is_read) ? rd_data : '0;
            rsp_tag   <= (accept && cls.is_read) ? rd_tag[0] : 1'b0;
            rsp_ok    <= commit;
            rsp_err   <= cls.err;
        end else begin
            rsp_rdata <= '0;
            rsp_tag   <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
        end
    end

    assign rsp_valid = (st_q == ST_RESP);

endmodule

// File: rtl/tmem_checker.sv
module tmem_checker
    import tmem_pkg::*;
#(
    parameter int NUM_GRANULES = 16,
    parameter int GIDX_W       = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [2:0]              req_op,
    input logic                    dec_err,
    input logic [GIDX_W-1:0]       gidx,
    input logic                    rsp_valid,
    input logic                    rsp_ok,
    input logic                    rsp_err,
    input logic                    link_i,
    input logic [NUM_GRANULES-1:0] tag_bits
);

    logic cond_op;
    assign cond_op = (req_op == OP_CAP_WR_COND) || (req_op == OP_DAT_WR_COND);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_reset_clears: assert property (@(posedge clk)
        $rose(rst_n) |-> (!link_i && (tag_bits == '0)));

    a_r5_dwrite_clears_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_DAT_WR) && !dec_err) |=> !tag_bits[$past(gidx)]);

    a_r7_sc_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_op && !link_i) |=> (rsp_valid && !rsp_ok));

    a_r8_sc_drops_link: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_op && link_i && !dec_err) |=> (!link_i && rsp_ok));

    a_r10_err_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_ok);

endmodule

bind tmem_top tmem_checker #(
    .NUM_GRANULES (NUM_GRANULES),
    .GIDX_W       (GIDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .dec_err   (cls.err),
    .gidx      (gidx),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_err   (rsp_err),
    .link_i    (link_q),
    .tag_bits  (tag_bits)
);

// File: tb/tmem_top_bench.sv
module tmem_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 16;
    localparam int GB         = 32;
    localparam int GBITS      = GB * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_op = '0;
    logic [8:0]       req_addr = '0;
    logic [1:0]       req_size = '0;
    logic [GBITS-1:0] req_wdata = '0;
    logic             req_tag = 1'b0;
    logic             rsp_valid;
    logic [GBITS-1:0] rsp_rdata;
    logic             rsp_tag;
    logic             rsp_ok;
    logic             rsp_err;

    tmem_top #(.NUM_GRANULES(NG), .GRAN_BYTES(GB)) u_tmem_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_tag(rsp_tag), .rsp_ok(rsp_ok), .rsp_err(rsp_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [GBITS-1:0] rdata;
        bit               tag;
        bit               ok;
        bit               err;
        bit               chk_data;
        string            req;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    logic [7:0]  mdl_mem [NG][GB];
    bit          mdl_tag [NG];
    bit          mdl_link;
    int          mdl_lg;

    function automatic logic [GBITS-1:0] pat(int s);
        logic [GBITS-1:0] r;
        for (int i = 0; i < 8; i++) r[32*i +: 32] = 32'(s) * 32'h9E3779B9 + 32'(i) * 32'h01030507 + 32'h1;
        return r;
    endfunction

    function automatic logic [8:0] ga(int g, int off);
        return 9'(g * GB + off);
    endfunction

    task automatic apply(input logic [2:0] op, input logic [8:0] addr, input logic [1:0] size,
                         input logic [GBITS-1:0] wd, input bit tg, input string req, input bit chk = 1'b1);
        exp_t e;
        int   g, off, nb;
        bit   cond, succ;
        g = int'(addr[8:5]); off = int'(addr[4:0]); nb = 1 << size;
        e.rdata = '0; e.tag = 0; e.ok = 0; e.err = 0; e.chk_data = chk; e.req = req;
        if (op <= 3'd3) e.err = (off != 0);
        else if (op <= 3'd5) e.err = ((off % nb) != 0);
        else e.err = 1;
        if (!e.err) begin
            if (op <= 3'd1) begin
                for (int k = 0; k < GB; k++) e.rdata[8*k +: 8] = mdl_mem[g][k];
                e.tag = mdl_tag[g];
                e.ok  = 1;
                if (op == 3'd1) begin mdl_link = 1; mdl_lg = g; end
            end else begin
                cond = (op == 3'd3) || (op == 3'd5);
                succ = !cond || mdl_link;
                e.ok = succ;
                if (succ) begin
                    if (op <= 3'd3) begin
                        for (int k = 0; k < GB; k++) mdl_mem[g][k] = wd[8*k +: 8];
                        mdl_tag[g] = tg;
                    end else begin
                        for (int k = 0; k < nb; k++) mdl_mem[g][off+k] = wd[8*k +: 8];
                        mdl_tag[g] = 0;
                    end
                    if (cond) mdl_link = 0;
                    else if (mdl_link && mdl_lg == g) mdl_link = 0;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_size = size;
        req_wdata = wd; req_tag = tg;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        idle(3);
        rst_n = 1'b0;
        for (int g = 0; g < NG; g++) mdl_tag[g] = 0;
        mdl_link = 0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 reset response: rsp_valid=%b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
    endtask

    // Monitor: pops the oldest expectation for each response
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R1 spurious response: rsp_valid=1 expected 0");
            end else begin
                e = sb.pop_front();
                if (rsp_tag !== e.tag || rsp_ok !== e.ok || rsp_err !== e.err ||
                    (e.chk_data && rsp_rdata !== e.rdata)) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h tag=%0d ok=%0d err=%0d expected rdata=%h tag=%0d ok=%0d err=%0d",
                             e.req, rsp_rdata, rsp_tag, rsp_ok, rsp_err, e.rdata, e.tag, e.ok, e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < NG; g++) begin
            mdl_tag[g] = 0;
            for (int k = 0; k < GB; k++) mdl_mem[g][k] = '0;
        end
        mdl_link = 0; mdl_lg = 0;
        do_reset();

        // R2: tag after reset
        apply(3'd0, ga(2, 0), 2'd0, '0, 0, "R2 tag zero after reset", 0);
        // R3: capability store/load, both tag values, back-to-back
        apply(3'd2, ga(1, 0), 2'd0, pat(1), 1, "R3 cap store");
        apply(3'd0, ga(1, 0), 2'd0, '0, 0, "R3 cap load tag1");
        idle(1);
        apply(3'd2, ga(1, 0), 2'd0, pat(2), 0, "R3 cap store tag0");
        apply(3'd0, ga(1, 0), 2'd0, '0, 0, "R3 cap load tag0");
        // R4/R5: data stores of every size
        apply(3'd2, ga(3, 0), 2'd0, pat(3), 1, "R3 cap store g3");
        apply(3'd4, ga(3, 5), 2'd0, 256'hEE, 0, "R4 byte store");
        apply(3'd0, ga(3, 0), 2'd0, '0, 0, "R5 tag cleared after byte store");
        apply(3'd2, ga(3, 0), 2'd0, pat(4), 1, "R3 cap store g3 again");
        apply(3'd4, ga(3, 30), 2'd1, 256'hBEEF, 0, "R4 half store top");
        apply(3'd4, ga(3, 4), 2'd2, 256'h11223344, 0, "R4 word store");
        apply(3'd4, ga(3, 24), 2'd3, 256'h0123456789ABCDEF, 0, "R4 dword store top");
        apply(3'd0, ga(3, 0), 2'd0, '0, 0, "R4 merged bytes R5 tag");
        // R7: conditionals without link
        apply(3'd2, ga(4, 0), 2'd0, pat(5), 1, "R3 cap store g4");
        apply(3'd3, ga(4, 0), 2'd0, pat(6), 0, "R7 cap SC no link");
        apply(3'd5, ga(4, 8), 2'd3, 256'h55, 0, "R7 data SC no link");
        apply(3'd0, ga(4, 0), 2'd0, '0, 0, "R7 g4 unchanged");
        // R6/R8: reservation then conditionals
        apply(3'd1, ga(1, 0), 2'd0, '0, 0, "R6 load-reserve");
        apply(3'd3, ga(5, 0), 2'd0, pat(7), 1, "R8 cap SC success");
        apply(3'd0, ga(5, 0), 2'd0, '0, 0, "R8 cap SC wrote");
        apply(3'd3, ga(5, 0), 2'd0, pat(8), 0, "R8 link cleared by SC");
        apply(3'd1, ga(4, 0), 2'd0, '0, 0, "R6 load-reserve g4");
        apply(3'd5, ga(4, 8), 2'd3, 256'hCAFEF00DDEADBEEF, 0, "R8 data SC success");
        apply(3'd0, ga(4, 0), 2'd0, '0, 0, "R8 R5 data SC cleared tag");
        // R9: stores vs reservation
        apply(3'd2, ga(6, 0), 2'd0, pat(9), 1, "R3 cap store g6");
        apply(3'd1, ga(6, 0), 2'd0, '0, 0, "R6 load-reserve g6");
        apply(3'd4, ga(6, 2), 2'd1, 256'h7777, 0, "R9 store to reserved granule");
        apply(3'd3, ga(6, 0), 2'd0, pat(10), 1, "R9 SC after reserved store fails");
        apply(3'd1, ga(6, 0), 2'd0, '0, 0, "R6 load-reserve g6 again");
        apply(3'd2, ga(7, 0), 2'd0, pat(11), 1, "R9 store other granule");
        apply(3'd3, ga(6, 0), 2'd0, pat(12), 1, "R9 SC succeeds after other store");
        apply(3'd0, ga(6, 0), 2'd0, '0, 0, "R9 g6 holds SC data");
        // R10: errors change nothing
        apply(3'd2, ga(8, 0), 2'd0, pat(13), 1, "R3 cap store g8");
        apply(3'd0, ga(8, 1), 2'd0, '0, 0, "R10 misaligned cap load");
        apply(3'd4, ga(8, 2), 2'd2, 256'h99, 0, "R10 misaligned word store");
        apply(3'd2, ga(8, 16), 2'd0, pat(14), 0, "R10 misaligned cap store");
        apply(3'd7, ga(8, 0), 2'd0, pat(15), 0, "R10 unknown opcode");
        apply(3'd6, ga(8, 0), 2'd0, pat(15), 0, "R10 unknown opcode 6");
        apply(3'd0, ga(8, 0), 2'd0, '0, 0, "R10 g8 unchanged");
        apply(3'd1, ga(8, 0), 2'd0, '0, 0, "R6 load-reserve g8");
        apply(3'd5, ga(8, 3), 2'd1, 256'h44, 0, "R10 misaligned SC");
        apply(3'd3, ga(8, 0), 2'd0, pat(16), 1, "R10 link kept after error");
        idle(2);
        // R2: reset mid-run clears tags and link
        apply(3'd2, ga(9, 0), 2'd0, pat(17), 1, "R3 cap store g9");
        apply(3'd1, ga(9, 0), 2'd0, '0, 0, "R6 load-reserve g9");
        do_reset();
        apply(3'd0, ga(9, 0), 2'd0, '0, 0, "R2 tag cleared by reset", 0);
        apply(3'd3, ga(9, 0), 2'd0, pat(18), 1, "R2 link cleared by reset");
        idle(3);

        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R1 missing responses: pending=%0d expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule